// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block turns the system clock into CAN bit timing. A prescaler divides the clock into time quanta. A segment controller steps through three parts of each bit: a one-quantum synchronization segment, a first timing segment and a second timing segment. The received bus level is sampled at the boundary between the two timing segments. The block reports each sample with a strobe and the sampled level, and marks the start of every bit with a separate strobe.

The controller follows recessive-to-dominant edges on the received line to keep its phase aligned with the transmitter.
- A late edge lengthens the first timing segment.
- An early edge shortens the second timing segment.
- Both corrections are capped at a configurable jump width.
- While the frame logic reports the bus idle, an edge instead restarts the bit (hard synchronization).

The configuration is copied into a shadow register only while the enable input is low. A combinational check flags illegal settings. While the flag is set, or while the block is disabled, the timing counters stay in their reset state.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration inputs are copied into the shadow only on clock edges where `en` is low; changes while `en` is high have no effect on timing.
- R2: `cfg_err` is 1 exactly when the shadow holds prescaler 0, segment-1 setting below 3, segment-2 setting below 1, segment-1 setting not greater than segment-2 setting, or segment-2 setting below the jump setting. Out of reset the shadow is all zero, so `cfg_err` is 1.
- R3: While `en` is low or `cfg_err` is 1, `sample_stb` and `bit_start` stay 0. When running begins, the bit starts in the sync segment.
- R4: One time quantum lasts `cfg_brp` clock cycles.
- R5: With no edges, the bit time is 1 + (tseg1+1) + (tseg2+1) quanta. `bit_start` pulses for one clock as each new sync segment begins, and it never pulses together with `sample_stb`.
- R6: `sample_stb` pulses for one clock at the end of segment 1. `sample_bit` then holds the received level (after the `RX_SYNC` input flops) seen at that quantum boundary. Dominant is 0.
- R7: The received line is looked at on quantum boundaries. A recessive-to-dominant edge seen at the end of quantum c (0-based) of segment 1 lengthens segment 1 by min(c+1, sjw+1).
- R8: An edge seen at the end of quantum c of segment 2, of current length L, shortens segment 2 by min(L-c, sjw+1). The bit ends at once if the shortened length is no longer than c+1.
- R9: An edge in the sync segment causes no correction. At most one correction is made per bit. No correction is made when the last sampled bit was dominant.
- R10: An edge seen while `bus_idle` is 1 forces the next quantum to be a sync segment and pulses `bit_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; the configuration is captured while low |
| cfg_brp | input | BRP_W | Clocks per time quantum |
| cfg_tseg1 | input | TS1_W | Segment 1 setting (length = setting + 1) |
| cfg_tseg2 | input | TS2_W | Segment 2 setting (length = setting + 1) |
| cfg_sjw | input | SJW_W | Jump width setting (width = setting + 1) |
| rx_in | input | 1 | Received bus line, 0 = dominant |
| bus_idle | input | 1 | Bus idle indication from frame logic; enables hard sync |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Last sampled bus level |
| bit_start | output | 1 | One-clock pulse at each new bit |
| cfg_err | output | 1 | Shadow configuration is illegal |

## Verification
The length assertions assume that the shadow configuration stays frozen while running. That holds only if software changes settings with `en` low, so the stimulus always lowers `en` before it loads a new configuration. The stimulus also applies a deliberately ignored change while running, to show that it has no effect. The received line is driven on the falling clock edge and held for whole bit periods. These periods are chosen a few clocks longer or shorter than the nominal bit, so that late, early and sync-segment edges all occur. The `bus_idle` input is raised only in the hard-synchronization phase.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_TS1  = 2'd1,
      SEG_TS2  = 2'd2
   } cbt_seg_e;
endpackage

// File: rtl/cbt_cfg_reg.sv
module cbt_cfg_reg #(
   parameter int BRP_W   = 6,
   parameter int TS1_W   = 4,
   parameter int TS2_W   = 3,
   parameter int SJW_W   = 2,
   parameter int MIN_TS1 = 3,
   parameter int MIN_TS2 = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [BRP_W-1:0] brp_in,
   input  logic [TS1_W-1:0] ts1_in,
   input  logic [TS2_W-1:0] ts2_in,
   input  logic [SJW_W-1:0] sjw_in,
   output logic [BRP_W-1:0] brp_q,
   output logic [TS1_W-1:0] ts1_q,
   output logic [TS2_W-1:0] ts2_q,
   output logic [SJW_W-1:0] sjw_q,
   output logic             cfg_err
);
   localparam int CW = (TS1_W > TS2_W) ? TS1_W + 1 : TS2_W + 1;

   logic [CW-1:0] t1_x, t2_x, sj_x;
   logic          bad_brp, bad_t1, bad_t2, bad_order, bad_jump;

   // shadow register: loads only while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brp_q <= '0;
         ts1_q <= '0;
         ts2_q <= '0;
         sjw_q <= '0;
      end else if (!en) begin
         brp_q <= brp_in;
         ts1_q <= ts1_in;
         ts2_q <= ts2_in;
         sjw_q <= sjw_in;
      end
   end

   assign t1_x = CW'(ts1_q);
   assign t2_x = CW'(ts2_q);
   assign sj_x = CW'(sjw_q);

   assign bad_brp   = (brp_q == '0);
   assign bad_t1    = (t1_x < CW'(MIN_TS1));
   assign bad_t2    = (t2_x < CW'(MIN_TS2));
   assign bad_order = (t1_x <= t2_x);
   assign bad_jump  = (t2_x < sj_x);
   assign cfg_err   = bad_brp | bad_t1 | bad_t2 | bad_order | bad_jump;

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en) |-> $stable({brp_q, ts1_q, ts2_q, sjw_q})); // R1
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
   parameter int BRP_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [BRP_W-1:0] brp,
   output logic             tick
);
   logic [BRP_W-1:0] pc_q;
   logic             wrap;

   assign wrap = (pc_q == brp - 1'b1);
   assign tick = run & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pc_q <= '0;
      else if (!run)   pc_q <= '0;
      else if (wrap)   pc_q <= '0;
      else             pc_q <= pc_q + 1'b1;
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && brp > 1) |=> !tick); // R4
endmodule

// File: rtl/cbt_rx_sync.sv
module cbt_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_in,
   output logic rx_q
);
   if (STAGES == 0) begin : g_direct
      assign rx_q = rx_in;
   end else if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= 1'b1;
         else        s_q <= rx_in;
      end
      assign rx_q = s_q;
   end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s_q <= '1;
         else        s_q <= {s_q[STAGES-2:0], rx_in};
      end
      assign rx_q = s_q[STAGES-1];
   end
endmodule

// File: rtl/cbt_seg_ctrl.sv
module cbt_seg_ctrl
   import cbt_pkg::*;
#(
   parameter int TS1_W = 4,
   parameter int TS2_W = 3,
   parameter int SJW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             rx,
   input  logic             bus_idle,
   input  logic [TS1_W-1:0] ts1,
   input  logic [TS2_W-1:0] ts2,
   input  logic [SJW_W-1:0] sjw,
   output logic             sample_stb,
   output logic             sample_bit,
   output logic             bit_start
);
   localparam int L1MAX = (1 << TS1_W) + (1 << SJW_W);
   localparam int LEN_W = $clog2(L1MAX + 1);

   cbt_seg_e          seg_q, seg_d;
   logic [LEN_W-1:0]  cnt_q, cnt_d, len1_q, len1_d, len2_q, len2_d;
   logic              prev_q, prev_d, dom_q, dom_d, rs_q, rs_d;
   logic              stb_d, bit_d, bst_d;
   logic [LEN_W-1:0]  base1, base2, jump, cnt_inc, rem2, err_late, err_early, l1, l2;
   logic              edge_w, hard_w, rs_ok;

   assign base1    = LEN_W'(ts1) + LEN_W'(1);
   assign base2    = LEN_W'(ts2) + LEN_W'(1);
   assign jump     = LEN_W'(sjw) + LEN_W'(1);
   assign cnt_inc  = cnt_q + LEN_W'(1);
   assign rem2     = len2_q - cnt_q;
   assign err_late = (cnt_inc < jump) ? cnt_inc : jump;
   assign err_early = (rem2 < jump) ? rem2 : jump;

   // edges are judged on quantum boundaries only
   assign edge_w = tick & prev_q & ~rx;
   assign hard_w = edge_w & bus_idle;
   assign rs_ok  = edge_w & ~bus_idle & ~rs_q & ~dom_q;

   always_comb begin
      seg_d  = seg_q;
      cnt_d  = cnt_q;
      len1_d = len1_q;
      len2_d = len2_q;
      prev_d = prev_q;
      dom_d  = dom_q;
      rs_d   = rs_q;
      stb_d  = 1'b0;
      bst_d  = 1'b0;
      bit_d  = sample_bit;
      l1     = len1_q;
      l2     = len2_q;
      if (tick) begin
         prev_d = rx;
         if (hard_w) begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
            bst_d = 1'b1;
            rs_d  = 1'b0;
         end else begin
            case (seg_q)
               SEG_SYNC: begin
                  seg_d  = SEG_TS1;
                  cnt_d  = '0;
                  len1_d = base1;
                  len2_d = base2;
               end
               SEG_TS1: begin
                  if (rs_ok) begin
                     l1   = len1_q + err_late;
                     rs_d = 1'b1;
                  end
                  len1_d = l1;
                  if (cnt_inc == l1) begin
                     seg_d = SEG_TS2;
                     cnt_d = '0;
                     stb_d = 1'b1;
                     bit_d = rx;
                     dom_d = ~rx;
                  end else begin
                     cnt_d = cnt_inc;
                  end
               end
               SEG_TS2: begin
                  if (rs_ok) begin
                     l2   = len2_q - err_early;
                     rs_d = 1'b1;
                  end
                  len2_d = l2;
                  if (cnt_inc >= l2) begin
                     seg_d = SEG_SYNC;
                     cnt_d = '0;
                     bst_d = 1'b1;
                     rs_d  = 1'b0;
                  end else begin
                     cnt_d = cnt_inc;
                  end
               end
               default: begin
                  seg_d = SEG_SYNC;
                  cnt_d = '0;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q      <= SEG_SYNC;
         cnt_q      <= '0;
         len1_q     <= '0;
         len2_q     <= '0;
         prev_q     <= 1'b1;
         dom_q      <= 1'b0;
         rs_q       <= 1'b0;
         sample_stb <= 1'b0;
         sample_bit <= 1'b1;
         bit_start  <= 1'b0;
      end else if (!run) begin
         seg_q      <= SEG_SYNC;
         cnt_q      <= '0;
         len1_q     <= base1;
         len2_q     <= base2;
         prev_q     <= 1'b1;
         dom_q      <= 1'b0;
         rs_q       <= 1'b0;
         sample_stb <= 1'b0;
         bit_start  <= 1'b0;
      end else begin
         seg_q      <= seg_d;
         cnt_q      <= cnt_d;
         len1_q     <= len1_d;
         len2_q     <= len2_d;
         prev_q     <= prev_d;
         dom_q      <= dom_d;
         rs_q       <= rs_d;
         sample_stb <= stb_d;
         sample_bit <= bit_d;
         bit_start  <= bst_d;
      end
   end

   AST_BSTART_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start |-> seg_q == SEG_SYNC); // R5
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && bit_start)); // R5
   AST_SAMPLE_AT_TS2: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (seg_q == SEG_TS2 && cnt_q == '0)); // R6
   AST_TS1_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> len1_q <= base1 + jump); // R7
   AST_TS2_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> len2_q + jump >= base2); // R8
   AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!sample_stb && !bit_start && seg_q == SEG_SYNC)); // R3
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int BRP_W   = 6,
   parameter int TS1_W   = 4,
   parameter int TS2_W   = 3,
   parameter int SJW_W   = 2,
   parameter int MIN_TS1 = 3,
   parameter int MIN_TS2 = 1,
   parameter int RX_SYNC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [BRP_W-1:0] cfg_brp,
   input  logic [TS1_W-1:0] cfg_tseg1,
   input  logic [TS2_W-1:0] cfg_tseg2,
   input  logic [SJW_W-1:0] cfg_sjw,
   input  logic             rx_in,
   input  logic             bus_idle,
   output logic             sample_stb,
   output logic             sample_bit,
   output logic             bit_start,
   output logic             cfg_err
);
   if (BRP_W < 1 || TS1_W < 2 || TS2_W < 1 || SJW_W < 1) begin : g_bad_width
      $error("can_bit_timer: field widths too small");
   end
   if (SJW_W > TS2_W) begin : g_bad_jump
      $error("can_bit_timer: jump field wider than segment 2 field");
   end
   if (RX_SYNC < 0 || RX_SYNC > 4) begin : g_bad_sync
      $error("can_bit_timer: RX_SYNC out of range");
   end

   logic [BRP_W-1:0] brp_s;
   logic [TS1_W-1:0] ts1_s;
   logic [TS2_W-1:0] ts2_s;
   logic [SJW_W-1:0] sjw_s;
   logic             run, tick, rx_s;

   cbt_cfg_reg #(
      .BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W),
      .MIN_TS1(MIN_TS1), .MIN_TS2(MIN_TS2)
   ) cfg_i (
      .clk(clk), .rst_n(rst_n), .en(en),
      .brp_in(cfg_brp), .ts1_in(cfg_tseg1), .ts2_in(cfg_tseg2), .sjw_in(cfg_sjw),
      .brp_q(brp_s), .ts1_q(ts1_s), .ts2_q(ts2_s), .sjw_q(sjw_s),
      .cfg_err(cfg_err)
   );

   assign run = en & ~cfg_err;

   cbt_prescaler #(.BRP_W(BRP_W)) pre_i (
      .clk(clk), .rst_n(rst_n), .run(run), .brp(brp_s), .tick(tick)
   );

   cbt_rx_sync #(.STAGES(RX_SYNC)) rxs_i (
      .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_q(rx_s)
   );

   cbt_seg_ctrl #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) seg_i (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rx(rx_s),
      .bus_idle(bus_idle), .ts1(ts1_s), .ts2(ts2_s), .sjw(sjw_s),
      .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_start(bit_start)
   );

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> (!sample_stb && !bit_start)); // R3
endmodule

// File: tb/can_bit_timer_tb_top.sv
module can_bit_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [5:0] cfg_brp = '0;
   logic [3:0] cfg_tseg1 = '0;
   logic [2:0] cfg_tseg2 = '0;
   logic [1:0] cfg_sjw = '0;
   logic       rx_in = 1'b1;
   logic       bus_idle = 1'b0;
   logic       sample_stb, sample_bit, bit_start, cfg_err;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   string cur_req = "R3";

   always #4 clk = ~clk;

   can_bit_timer dut_i (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_brp(cfg_brp), .cfg_tseg1(cfg_tseg1), .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw),
      .rx_in(rx_in), .bus_idle(bus_idle),
      .sample_stb(sample_stb), .sample_bit(sample_bit), .bit_start(bit_start),
      .cfg_err(cfg_err)
   );

   function automatic bit illegal(int b, int t1, int t2, int s);
      return (b == 0) || (t1 < 3) || (t2 < 1) || (t1 <= t2) || (t2 < s);
   endfunction

   // behavioural reference model
   int m_brp = 0, m_t1 = 0, m_t2 = 0, m_sj = 0;
   int m_pc = 0, m_seg = 0, m_cnt = 0, m_len1 = 0, m_len2 = 0;
   bit m_prev = 1, m_dom = 0, m_rs = 0, m_s0 = 1, m_s1 = 1;
   bit m_stb = 0, m_bit = 1, m_bst = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_brp = 0; m_t1 = 0; m_t2 = 0; m_sj = 0;
         m_pc = 0; m_seg = 0; m_cnt = 0; m_len1 = 0; m_len2 = 0;
         m_prev = 1; m_dom = 0; m_rs = 0; m_s0 = 1; m_s1 = 1;
         m_stb = 0; m_bit = 1; m_bst = 0;
      end else begin
         automatic bit run = en && !illegal(m_brp, m_t1, m_t2, m_sj);
         automatic bit tick = run && (m_pc == m_brp - 1);
         automatic bit rx = m_s1;
         automatic int jw = m_sj + 1;
         if (!run) begin
            m_seg = 0; m_cnt = 0; m_len1 = m_t1 + 1; m_len2 = m_t2 + 1;
            m_prev = 1; m_dom = 0; m_rs = 0; m_stb = 0; m_bst = 0; m_pc = 0;
         end else begin
            automatic bit edg = tick && m_prev && !rx;
            m_stb = 0; m_bst = 0;
            if (tick) begin
               m_prev = rx;
               if (edg && bus_idle) begin
                  m_seg = 0; m_cnt = 0; m_bst = 1; m_rs = 0;
               end else if (m_seg == 0) begin
                  m_seg = 1; m_cnt = 0; m_len1 = m_t1 + 1; m_len2 = m_t2 + 1;
               end else if (m_seg == 1) begin
                  if (edg && !m_rs && !m_dom) begin
                     m_len1 += (m_cnt + 1 < jw) ? m_cnt + 1 : jw;
                     m_rs = 1;
                  end
                  if (m_cnt + 1 == m_len1) begin
                     m_seg = 2; m_cnt = 0; m_stb = 1; m_bit = rx; m_dom = !rx;
                  end else m_cnt++;
               end else begin
                  if (edg && !m_rs && !m_dom) begin
                     m_len2 -= (m_len2 - m_cnt < jw) ? m_len2 - m_cnt : jw;
                     m_rs = 1;
                  end
                  if (m_cnt + 1 >= m_len2) begin
                     m_seg = 0; m_cnt = 0; m_bst = 1; m_rs = 0;
                  end else m_cnt++;
               end
            end
            m_pc = tick ? 0 : m_pc + 1;
         end
         if (!en) begin
            m_brp = cfg_brp; m_t1 = cfg_tseg1; m_t2 = cfg_tseg2; m_sj = cfg_sjw;
         end
         m_s1 = m_s0; m_s0 = rx_in;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk({cur_req, " sample_stb"}, sample_stb, m_stb);
         chk({cur_req, " sample_bit"}, sample_bit, m_bit);
         chk({cur_req, " bit_start"}, bit_start, m_bst);
         chk({cur_req, " cfg_err"}, cfg_err, illegal(m_brp, m_t1, m_t2, m_sj));
      end
   end

   task automatic load(int b, int t1, int t2, int s);
      @(negedge clk);
      en = 1'b0;
      cfg_brp = 6'(b); cfg_tseg1 = 4'(t1); cfg_tseg2 = 3'(t2); cfg_sjw = 2'(s);
      repeat (2) @(negedge clk);
   endtask

   task automatic measure(string req, int exp);
      int first = -1;
      int guard = 0;
      while (guard < 2000) begin
         @(negedge clk);
         guard++;
         if (bit_start) begin
            if (first < 0) first = cyc;
            else break;
         end
      end
      chk({req, " bit period"}, (first < 0) ? -1 : cyc - first, exp);
   endtask

   task automatic send(logic [15:0] pat, int per);
      for (int i = 0; i < 16; i++) begin
         rx_in = pat[i];
         repeat (per) @(negedge clk);
      end
      rx_in = 1'b1;
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset cfg_err", cfg_err, 1);
      chk("R3 reset sample_stb", sample_stb, 0);
      chk("R3 reset bit_start", bit_start, 0);

      cur_req = "R2";
      load(2, 5, 3, 1);  chk("R2 legal", cfg_err, 0);
      load(0, 5, 3, 1);  chk("R2 zero prescaler", cfg_err, 1);
      load(2, 2, 1, 0);  chk("R2 short seg1", cfg_err, 1);
      load(2, 5, 0, 0);  chk("R2 zero seg2", cfg_err, 1);
      load(2, 4, 4, 0);  chk("R2 seg1 not longer", cfg_err, 1);
      load(2, 5, 1, 2);  chk("R2 seg2 below jump", cfg_err, 1);
      load(2, 15, 7, 3); chk("R2 max legal", cfg_err, 0);
      load(1, 3, 2, 2);  chk("R2 min legal", cfg_err, 0);

      cur_req = "R5";
      load(2, 5, 3, 1);
      en = 1'b1;
      measure("R5", 22);
      cur_req = "R4";
      load(1, 5, 3, 1); en = 1'b1; measure("R4 brp1", 11);
      load(3, 5, 3, 1); en = 1'b1; measure("R4 brp3", 33);

      cur_req = "R1";
      cfg_brp = 6'd7; cfg_tseg1 = 4'd9; cfg_tseg2 = 3'd2;
      measure("R1 ignored change", 33);

      cur_req = "R6";
      load(2, 5, 3, 1); en = 1'b1;
      send(16'b0110_1011_0010_1101, 22);
      cur_req = "R7";
      send(16'b1010_0101_1010_0101, 25);
      cur_req = "R8";
      send(16'b1010_0110_1010_0101, 19);
      cur_req = "R9";
      load(2, 6, 3, 0); en = 1'b1;
      send(16'b0010_0100_1001_0101, 27);
      send(16'b0101_0100_0100_1001, 17);
      send(16'b0001_1000_1110_0101, 22);

      cur_req = "R10";
      load(2, 5, 3, 2); en = 1'b1;
      repeat (7) @(negedge clk);
      bus_idle = 1'b1;
      send(16'b1110_1101_1011_0111, 13);
      bus_idle = 1'b0;
      repeat (40) @(negedge clk);

      cur_req = "R3";
      load(2, 4, 4, 0); en = 1'b1;
      begin
         int seen = 0;
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample_stb || bit_start) seen++;
         end
         chk("R3 strobes with illegal cfg", seen, 0);
      end
      load(2, 5, 3, 1);
      chk("R3 strobes while disabled", sample_stb | bit_start, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule